// File: doc/BRIEF.md
# Cache Invalidation Sequencer

This block runs the maintenance sweep that empties an instruction cache. The sweep walks every set index once, from zero upward, and strobes a valid-clear into the tag store for both ways of that set. A sweep starts when software writes the control register with the invalidate bit set. It also starts on its own when a control write takes the cache from enabled to disabled. While a sweep runs, the cache is bypassed. On completion, a sticky end-of-busy flag is raised, and it can interrupt the processor.

Software sees four registers as plain write strobes and read-back buses:
- control: enable in bit 0, way select in bit 1 (1 means two-way, 0 means direct-mapped), invalidate in bit 2;
- status: busy in bit 0, busy-end in bit 1, error in bit 2;
- interrupt enable: busy-end in bit 0, error in bit 1;
- flag clear, write-one-to-clear: busy-end in bit 0, error in bit 1.

An error input pulse from the cache sets the sticky error flag. The tag store and the data path sit outside this block.

The controller is a two-state machine. IDLE goes to SWEEP on a start request (a software invalidate or the automatic start on disable). SWEEP stays in SWEEP while the index is below the last set. SWEEP goes back to IDLE on the last set, which completes the sweep.

Top module: `cache_inval_seq`

## Requirements
- R1: After reset the control read-back is 3'b010 (disabled, two-way, no invalidate). Status, interrupt enables, irq and clr_we are all 0.
- R2: A control write with bit 2 set while idle starts a sweep from the next cycle. The sweep asserts clr_we for exactly NUM_SETS consecutive cycles, with clr_idx running 0, 1, ... NUM_SETS-1.
- R3: A control write that clears bit 0 while the enable read-back is 1 starts the same sweep, even though bit 2 is 0.
- R4: Status bit 0 (busy) is 1 for the whole sweep. The cycle busy falls, status bit 1 (busy-end) becomes 1 and control bit 2 reads 0. Busy-end stays 1 until cleared.
- R5: An invalidate request, or a disable, written while busy starts nothing: the running sweep keeps its length and no second sweep follows.
- R6: A flag-clear write clears busy-end with bit 0 and error with bit 1. A 0 bit leaves its flag alone, and a flag being set in the same cycle wins over the clear.
- R7: bypass is 1 whenever the enable bit is 0 or busy is 1, including when software enables the cache during a sweep.
- R8: irq is 1 exactly when (busy-end and interrupt-enable bit 0) or (error and interrupt-enable bit 1).
- R9: Writes to control bit 1 (way select) take effect only while the enable read-back is 0. Otherwise they are ignored.
- R10: A one-cycle err_pulse sets status bit 2 (error) from the next cycle, and the bit stays set until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data: enable, way select, invalidate |
| ien_we | input | 1 | Interrupt-enable register write strobe |
| ien_wdata | input | 2 | Interrupt-enable write data: busy-end, error |
| fclr_we | input | 1 | Flag-clear register write strobe |
| fclr_wdata | input | 2 | Write-one-to-clear bits: busy-end, error |
| err_pulse | input | 1 | Error event from the cache |
| ctrl_q | output | 3 | Control register read-back |
| stat_q | output | 3 | Status: busy, busy-end, error |
| ien_q | output | 2 | Interrupt-enable read-back |
| irq | output | 1 | Interrupt request |
| bypass | output | 1 | Route accesses around the cache |
| clr_we | output | 1 | Valid-clear strobe to the tag store (both ways) |
| clr_idx | output | IDX_W | Set index being cleared |

## Verification
The assertions watch the invariants that hold on every cycle:
- bypass holds while busy;
- the clear strobe appears only while busy, and its index starts at zero and steps by one;
- busy-end is set the cycle busy drops;
- the way bit is frozen while enabled;
- flag clears and error sets land one cycle later;
- an enabled, set flag drives irq.

Only the bench scenarios can show sweep length and its start from each trigger, that requests made mid-sweep are dropped with no later restart, and the effect of ordered write sequences on the read-back registers.

// File: rtl/cis_pkg.sv
package cis_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_WAY = 1;
    localparam int CTL_INV = 2;

    localparam int STS_BUSY = 0;
    localparam int STS_BEND = 1;
    localparam int STS_ERR  = 2;

    localparam int IEN_BEND = 0;
    localparam int IEN_ERR  = 1;
endpackage

// File: rtl/cis_sweep.sv
module cis_sweep
    import cis_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SETS - 1);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    assign at_last = (idx_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_SWEEP;
            ST_SWEEP: if (at_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   idx_q <= '0;
        else if (state_q == ST_SWEEP) idx_q <= at_last ? '0 : idx_q + 1'b1;
        else                          idx_q <= '0;
    end

    always_comb begin
        busy    = (state_q == ST_SWEEP);
        done    = busy && at_last;
        clr_we  = busy;
        clr_idx = idx_q;
    end
endmodule

// File: rtl/cis_regs.sv
module cis_regs
    import cis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [2:0] ctrl_wdata,
    input  logic       ien_we,
    input  logic [1:0] ien_wdata,
    input  logic       fclr_we,
    input  logic [1:0] fclr_wdata,
    input  logic       err_pulse,
    input  logic       busy,
    input  logic       done,
    output logic       start,
    output logic       en_q,
    output logic       way_q,
    output logic       inv_q,
    output logic       bend_q,
    output logic       err_q,
    output logic [1:0] ien_q
);
    logic sw_start, auto_start;

    assign sw_start   = ctrl_we && ctrl_wdata[CTL_INV] && !busy;
    assign auto_start = ctrl_we && en_q && !ctrl_wdata[CTL_EN] && !busy;
    assign start      = sw_start || auto_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            way_q <= 1'b1;
        end else if (ctrl_we) begin
            en_q <= ctrl_wdata[CTL_EN];
            if (!en_q) way_q <= ctrl_wdata[CTL_WAY];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        inv_q <= 1'b0;
        else if (done)     inv_q <= 1'b0;
        else if (sw_start) inv_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (done)                                bend_q <= 1'b1;
            else if (fclr_we && fclr_wdata[IEN_BEND]) bend_q <= 1'b0;
            if (err_pulse)                           err_q <= 1'b1;
            else if (fclr_we && fclr_wdata[IEN_ERR])  err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= ien_wdata;
    end
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
    import cis_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [2:0]       ctrl_wdata,
    input  logic             ien_we,
    input  logic [1:0]       ien_wdata,
    input  logic             fclr_we,
    input  logic [1:0]       fclr_wdata,
    input  logic             err_pulse,
    output logic [2:0]       ctrl_q,
    output logic [2:0]       stat_q,
    output logic [1:0]       ien_q,
    output logic             irq,
    output logic             bypass,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);
    logic busy, done, start;
    logic en_q, way_q, inv_q, bend_q, err_q;

    cis_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ien_we     (ien_we),
        .ien_wdata  (ien_wdata),
        .fclr_we    (fclr_we),
        .fclr_wdata (fclr_wdata),
        .err_pulse  (err_pulse),
        .busy       (busy),
        .done       (done),
        .start      (start),
        .en_q       (en_q),
        .way_q      (way_q),
        .inv_q      (inv_q),
        .bend_q     (bend_q),
        .err_q      (err_q),
        .ien_q      (ien_q)
    );

    cis_sweep #(.NUM_SETS(NUM_SETS)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .clr_we  (clr_we),
        .clr_idx (clr_idx)
    );

    always_comb begin
        ctrl_q = {inv_q, way_q, en_q};
        stat_q = {err_q, bend_q, busy};
        irq    = (bend_q && ien_q[IEN_BEND]) || (err_q && ien_q[IEN_ERR]);
        bypass = !en_q || busy;
    end
endmodule

// File: rtl/cis_checker.sv
module cis_checker #(
    parameter int NUM_SETS = 16,
    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ctrl_q,
    input logic [2:0]       stat_q,
    input logic [1:0]       ien_q,
    input logic             irq,
    input logic             bypass,
    input logic             clr_we,
    input logic [IDX_W-1:0] clr_idx,
    input logic             err_pulse,
    input logic             fclr_we,
    input logic [1:0]       fclr_wdata
);
    // R7
    busy_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] |-> bypass);

    // R2
    clr_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |-> stat_q[0]);

    // R2
    clr_first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_we) |-> clr_idx == '0);

    // R2
    clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && $past(clr_we)) |-> clr_idx == IDX_W'($past(clr_idx) + 1'b1));

    // R4
    bend_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[0]) |-> (stat_q[1] && !ctrl_q[2]));

    // R9
    way_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> $stable(ctrl_q[1]));

    // R6
    bend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr_we && fclr_wdata[0] && !stat_q[0]) |=> !stat_q[1]);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> stat_q[2]);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q[1] && ien_q[0]) || (stat_q[2] && ien_q[1])) |-> irq);
endmodule

bind cache_inval_seq cis_checker #(.NUM_SETS(NUM_SETS)) u_chk (.*);

// File: tb/cache_inval_seq_test.sv
module cache_inval_seq_test;
    localparam int NSETS = 16;
    localparam int IW = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [2:0]    ctrl_wdata = '0;
    logic          ien_we = 1'b0;
    logic [1:0]    ien_wdata = '0;
    logic          fclr_we = 1'b0;
    logic [1:0]    fclr_wdata = '0;
    logic          err_pulse = 1'b0;
    logic [2:0]    ctrl_q, stat_q;
    logic [1:0]    ien_q;
    logic          irq, bypass, clr_we;
    logic [IW-1:0] clr_idx;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    cache_inval_seq #(.NUM_SETS(NSETS)) uut (.*);

    // entry: {write data, expected ctrl read-back, expected busy}
    localparam logic [6:0] VEC [6] = '{
        {3'b011, 3'b011, 1'b0},   // R1 baseline enable, two-way
        {3'b001, 3'b011, 1'b0},   // R9 way change while enabled ignored
        {3'b000, 3'b010, 1'b1},   // R3 disable starts sweep
        {3'b000, 3'b000, 1'b0},   // R9 way change while disabled accepted
        {3'b100, 3'b100, 1'b1},   // R2 software invalidate
        {3'b001, 3'b001, 1'b0}    // R9 enable in direct-mapped mode
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [2:0] d);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_ien(input logic [1:0] d);
        ien_we = 1'b1; ien_wdata = d;
        @(negedge clk);
        ien_we = 1'b0;
    endtask

    task automatic wr_fclr(input logic [1:0] d);
        fclr_we = 1'b1; fclr_wdata = d;
        @(negedge clk);
        fclr_we = 1'b0;
    endtask

    // counts sweep cycles from the current negedge; checks index order
    task automatic run_sweep(input int first, output int n, output bit ok);
        n = 0; ok = 1'b1;
        while (stat_q[0] && n < 4 * NSETS) begin
            if (!clr_we || int'(clr_idx) != first + n || !bypass) ok = 1'b0;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_no_busy(input int cycles, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if (stat_q[0] || clr_we) seen = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int  n;
        bit  ok;
        bit  seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", int'(ctrl_q), 2);
        check("R1 stat", int'(stat_q), 0);
        check("R1 ien/irq/clr", int'({ien_q, irq, clr_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < 6; v++) begin
            wr_ctrl(VEC[v][6:4]);
            check($sformatf("R9/R2/R3 vec%0d ctrl", v), int'(ctrl_q), int'(VEC[v][3:1]));
            check($sformatf("R4 vec%0d busy", v), int'(stat_q[0]), int'(VEC[v][0]));
            if (VEC[v][0]) begin
                run_sweep(0, n, ok);
                check($sformatf("R2 vec%0d length", v), n, NSETS);
                check($sformatf("R2 vec%0d index order", v), int'(ok), 1);
                check($sformatf("R4 vec%0d busy-end set", v), int'(stat_q[1:0]), 2);
                check($sformatf("R4 vec%0d inv cleared", v), int'(ctrl_q[2]), 0);
                @(negedge clk);
                check($sformatf("R4 vec%0d sticky", v), int'(stat_q[1]), 1);
                wr_fclr(2'b01);
                check($sformatf("R6 vec%0d busy-end cleared", v), int'(stat_q[1]), 0);
            end
        end

        // R7 bypass off when enabled and idle
        check("R7 enabled idle bypass", int'(bypass), 0);

        // R3/R5/R7: disable, then enable with invalidate mid-sweep
        wr_ctrl(3'b010);
        @(negedge clk);
        @(negedge clk);
        wr_ctrl(3'b111);
        check("R7 bypass after mid-sweep enable", int'(bypass), 1);
        check("R5 inv ignored while busy", int'(ctrl_q), 3'b011);
        run_sweep(3, n, ok);
        check("R5 sweep length kept", n + 3, NSETS);
        check("R5 index order kept", int'(ok), 1);
        check("R7 bypass released", int'(bypass), 0);
        idle_no_busy(NSETS + 2, seen);
        check("R5 no second sweep", int'(seen), 0);

        // R5: disable while busy starts nothing extra
        wr_ctrl(3'b101);
        wr_ctrl(3'b000);
        run_sweep(1, n, ok);
        check("R5 disable mid-sweep length", n + 1, NSETS);
        idle_no_busy(NSETS + 2, seen);
        check("R5 disable mid-sweep no restart", int'(seen), 0);

        // R8 interrupt gating
        check("R8 bend without enable", int'(irq), 0);
        wr_ien(2'b01);
        check("R8 bend enabled", int'(irq), 1);
        wr_fclr(2'b01);
        check("R8 irq after clear", int'(irq), 0);

        // R10 error flag
        err_pulse = 1'b1;
        @(negedge clk);
        err_pulse = 1'b0;
        check("R10 error set", int'(stat_q[2]), 1);
        check("R8 error not enabled", int'(irq), 0);
        repeat (3) @(negedge clk);
        check("R10 error sticky", int'(stat_q[2]), 1);
        wr_ien(2'b10);
        check("R8 error enabled", int'(irq), 1);

        // R6: zero bit no effect, set wins over clear
        wr_ctrl(3'b100);
        run_sweep(0, n, ok);
        wr_fclr(2'b01);
        check("R6 error kept by zero bit", int'(stat_q[2:1]), 2);
        err_pulse = 1'b1; fclr_we = 1'b1; fclr_wdata = 2'b10;
        @(negedge clk);
        err_pulse = 1'b0; fclr_we = 1'b0;
        check("R6 set wins over clear", int'(stat_q[2]), 1);
        wr_fclr(2'b10);
        check("R6 error cleared", int'(stat_q[2]), 0);
        check("R8 irq low", int'(irq), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule